// File: doc/BRIEF.md
# Averaging Measurement Sequencer

This block paces a single filtered measurement on the converter's internal conversion clock. When a start request is accepted, it runs a fixed burst of seven sample-and-convert slots. It then runs a filter slot of fixed length and raises a one-cycle completion pulse. The analog converter and the filter arithmetic sit outside the block. It drives them through a per-conversion strobe with a conversion index and through a filter-active level.

The resolution input selects the slot length: 19 cycles per conversion at 12 bits and 16 cycles at 8 bits. The first acquisition overlaps the preceding serial transfer, so the first slot is four cycles shorter than the others. The cycle total is therefore fixed: 148 cycles at 12 bits and 127 at 8 bits.

A running cycle tally is exposed so that a checker can compare it against that total. If the serial side is still busy when filtering ends, completion is held back until it is free. The serial frame lengths that the host uses to read the result are 16 or 24 clocks plus one gap clock, and 8 clocks plus one gap clock in the shortened 8-bit output format. They matter only for throughput and are not produced here.

Top module: `avg_meas_seq`

## Requirements
- R1: A measurement produces exactly seven `conv_strobe` pulses, one cycle each. During each pulse, `conv_idx` holds 0, 1, …, 6 in order.
- R2: With `res_12b`=1 sampled at start, consecutive conversion strobes are 19 cycles apart.
- R3: With `res_12b`=0 sampled at start, consecutive conversion strobes are 16 cycles apart.
- R4: The first conversion is shortened by 4 cycles. Counting the first cycle after the start edge as cycle 1, its strobe falls in cycle (slot length − 4).
- R5: `filt_active` is high for exactly 19 consecutive cycles. These begin in the cycle after the seventh strobe.
- R6: While `done` is high, `cycle_count` equals 148 in 12-bit mode and 127 in 8-bit mode. The count holds until the next accepted start.
- R7: `done` is high for exactly one cycle. It is the cycle after the last filter cycle when `io_busy` is low at that edge. Otherwise it is the cycle after the first edge at which `io_busy` is seen low.
- R8: A start request is accepted only when idle. A start that arrives during a measurement does not change the strobe, filter or done timing, nor the final count.
- R9: `res_12b` is captured when start is accepted. Changing it during a measurement does not change that measurement's timing.
- R10: A synchronous active-high reset returns the block to idle in the next cycle, with `done`, `filt_active` and `conv_strobe` low and `conv_idx` and `cycle_count` at zero. No strobe or done follows until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Measurement request, accepted when idle |
| res_12b | input | 1 | 1 selects 12-bit slots, 0 selects 8-bit slots |
| io_busy | input | 1 | Serial transfer still in progress; holds off completion |
| conv_strobe | output | 1 | One-cycle pulse at the end of each conversion slot |
| conv_idx | output | 3 | Index of the current conversion, 0 to 6 |
| filt_active | output | 1 | High during the filter slot |
| done | output | 1 | One-cycle completion pulse |
| cycle_count | output | 8 | Conversion plus filter cycles since the last accepted start |

## Verification
Measurements are run in both resolutions. A mismatch in strobe spacing or in total count separates the 19-cycle slot from the 16-cycle slot, and the position of the first strobe exposes a missing or wrong overlap. Runs with `io_busy` held past the end of filtering for different numbers of cycles separate a wait on the busy line from a fixed delay. Runs that raise start again or toggle the resolution mid-measurement show whether either input leaks into a run already under way. A reset in mid-burst shows that the block returns to a quiet idle state.

// File: rtl/avgm_pkg.sv
package avgm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CONV,
        S_FILT,
        S_HOLD,
        S_DONE
    } avgm_state_e;

    function automatic int unsigned avgm_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned avgm_slot_len(input logic hi, input int unsigned len_hi,
                                                  input int unsigned len_lo);
        return hi ? len_hi : len_lo;
    endfunction

    function automatic int unsigned avgm_total(input int unsigned n_conv, input int unsigned len,
                                               input int unsigned filt, input int unsigned overlap);
        return n_conv * len + filt - overlap;
    endfunction

endpackage

// File: rtl/avgm_step_counter.sv
module avgm_step_counter #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         advance,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (advance) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/avgm_fsm.sv
module avgm_fsm
    import avgm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        io_busy,
    input  logic        burst_end,
    input  logic        filt_end,
    output avgm_state_e state,
    output logic        start_acc
);

    avgm_state_e state_nx;

    assign start_acc = (state == S_IDLE) && start;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = S_CONV;
            S_CONV: if (burst_end) state_nx = S_FILT;
            S_FILT: if (filt_end) state_nx = io_busy ? S_HOLD : S_DONE;
            S_HOLD: if (!io_busy) state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    // R7: completion lasts a single cycle
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_DONE) |=> (state == S_IDLE));

    // R7: completion waits while the serial side is busy
    assert_hold_waits_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_HOLD && io_busy) |=> (state == S_HOLD));

endmodule

// File: rtl/avg_meas_seq.sv
module avg_meas_seq
    import avgm_pkg::*;
#(
    parameter int unsigned NUM_CONV    = 7,
    parameter int unsigned SLOT_HI     = 19,
    parameter int unsigned SLOT_LO     = 16,
    parameter int unsigned FILT_CYC    = 19,
    parameter int unsigned IO_OVERLAP  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic                         res_12b,
    input  logic                         io_busy,
    output logic                         conv_strobe,
    output logic [$clog2(NUM_CONV)-1:0]  conv_idx,
    output logic                         filt_active,
    output logic                         done,
    output logic [$clog2(NUM_CONV*avgm_max(SLOT_HI, SLOT_LO)+FILT_CYC+1)-1:0] cycle_count
);

    localparam int unsigned IW  = $clog2(NUM_CONV);
    localparam int unsigned PW  = $clog2(avgm_max(avgm_max(SLOT_HI, SLOT_LO), FILT_CYC));
    localparam int unsigned CW  = $clog2(NUM_CONV*avgm_max(SLOT_HI, SLOT_LO)+FILT_CYC+1);
    localparam int unsigned TOT_HI = avgm_total(NUM_CONV, SLOT_HI, FILT_CYC, IO_OVERLAP);
    localparam int unsigned TOT_LO = avgm_total(NUM_CONV, SLOT_LO, FILT_CYC, IO_OVERLAP);

    avgm_state_e   state;
    logic          start_acc;
    logic          res_q;
    logic [PW-1:0] phase;
    logic [PW-1:0] slot_last;
    logic          running;
    logic          conv_last;
    logic          burst_end;
    logic          filt_end;

    always_ff @(posedge clk) begin
        if (rst)            res_q <= 1'b0;
        else if (start_acc) res_q <= res_12b;
    end

    assign slot_last = PW'(avgm_slot_len(res_q, SLOT_HI, SLOT_LO) - 1);
    assign running   = (state == S_CONV) || (state == S_FILT);
    assign conv_last = (state == S_CONV) && (phase == slot_last);
    assign burst_end = conv_last && (conv_idx == IW'(NUM_CONV - 1));
    assign filt_end  = (state == S_FILT) && (phase == PW'(FILT_CYC - 1));

    avgm_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .io_busy   (io_busy),
        .burst_end (burst_end),
        .filt_end  (filt_end),
        .state     (state),
        .start_acc (start_acc)
    );

    // Phase within a slot; the first slot starts part-way in
    avgm_step_counter #(.W(PW)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .clear    (filt_end),
        .load     (start_acc || conv_last),
        .load_val (start_acc ? PW'(IO_OVERLAP) : '0),
        .advance  (running),
        .count    (phase)
    );

    avgm_step_counter #(.W(IW)) u_index (
        .clk      (clk),
        .rst      (rst),
        .clear    (start_acc),
        .load     (1'b0),
        .load_val ('0),
        .advance  (conv_last && !burst_end),
        .count    (conv_idx)
    );

    avgm_step_counter #(.W(CW)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .clear    (start_acc),
        .load     (1'b0),
        .load_val ('0),
        .advance  (running),
        .count    (cycle_count)
    );

    assign conv_strobe = conv_last;
    assign filt_active = (state == S_FILT);
    assign done        = (state == S_DONE);

    assert_idx_range_R1: assert property (@(posedge clk) disable iff (rst)
        conv_idx <= IW'(NUM_CONV - 1));

    assert_filt_follows_R5: assert property (@(posedge clk) disable iff (rst)
        (conv_strobe && conv_idx == IW'(NUM_CONV - 1)) |=> filt_active);

    assert_total_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (cycle_count == (res_q ? CW'(TOT_HI) : CW'(TOT_LO))));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (running && start) |=> (cycle_count != '0));

    assert_res_held_R9: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(res_q));

    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (!done && !filt_active && cycle_count == '0 && conv_idx == '0));

endmodule

// File: tb/tb_avg_meas_seq.sv
`timescale 1ns/1ps
module tb_avg_meas_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       res_12b = 1'b0;
    logic       io_busy = 1'b0;
    logic       conv_strobe;
    logic [2:0] conv_idx;
    logic       filt_active;
    logic       done;
    logic [7:0] cycle_count;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    avg_meas_seq dut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .res_12b     (res_12b),
        .io_busy     (io_busy),
        .conv_strobe (conv_strobe),
        .conv_idx    (conv_idx),
        .filt_active (filt_active),
        .done        (done),
        .cycle_count (cycle_count)
    );

    typedef struct packed {
        logic       res;
        logic [3:0] extra;
        logic [7:0] poke;
        logic [7:0] flip;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd0, 8'd0,  8'd0},
        '{1'b0, 4'd0, 8'd0,  8'd0},
        '{1'b1, 4'd3, 8'd0,  8'd0},
        '{1'b0, 4'd2, 8'd0,  8'd0},
        '{1'b1, 4'd0, 8'd40, 8'd0},
        '{1'b0, 4'd0, 8'd0,  8'd7},
        '{1'b1, 4'd1, 8'd60, 8'd20}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One full measurement, checked cycle by cycle against the requirements
    task automatic run_meas(input logic res, input int extra, input int poke, input int flip);
        int  slen    = res ? 19 : 16;
        int  fend    = 7 * slen + 15;
        int  done_at = fend + 1 + extra;
        int  first_at = -1;
        int  n_strobes = 0;
        int  sp_bad = 0, sp_act = 0, sp_exp = 0;
        int  ix_bad = 0, ix_act = 0, ix_exp = 0;
        int  fl_bad = 0, fl_act = 0, fl_exp = 0;
        int  dn_bad = 0, dn_act = 0;
        int  cnt_at_done = -1;
        string slot_req = res ? "R2" : "R3";
        @(negedge clk);
        res_12b = res;
        start   = 1'b1;
        io_busy = (extra > 0);
        for (int n = 1; n <= done_at + 2; n++) begin
            bit exp_s, exp_f, exp_d;
            int rel;
            @(negedge clk);
            rel   = n - (slen - 4);
            exp_s = (rel >= 0) && (rel % slen == 0) && (rel / slen < 7);
            exp_f = (n >= fend - 18) && (n <= fend);
            exp_d = (n == done_at);
            if (conv_strobe) begin
                n_strobes++;
                if (first_at < 0) first_at = n;
            end
            if (conv_strobe !== exp_s && sp_bad == 0) begin
                sp_bad = 1; sp_act = n; sp_exp = int'(exp_s);
            end
            if (conv_strobe && exp_s && conv_idx != 3'(rel / slen) && ix_bad == 0) begin
                ix_bad = 1; ix_act = int'(conv_idx); ix_exp = rel / slen;
            end
            if (filt_active !== exp_f && fl_bad == 0) begin
                fl_bad = 1; fl_act = n; fl_exp = int'(exp_f);
            end
            if (done !== exp_d && dn_bad == 0) begin
                dn_bad = 1; dn_act = n;
            end
            if (exp_d) cnt_at_done = int'(cycle_count);
            start = (n == poke);
            if (n == flip) res_12b = ~res_12b;
            io_busy = (extra > 0) && (n < fend + extra);
        end
        start   = 1'b0;
        io_busy = 1'b0;
        check(n_strobes == 7, "R1 strobe count", n_strobes, 7);
        check(ix_bad == 0, "R1 conv_idx at strobe", ix_act, ix_exp);
        check(sp_bad == 0, {slot_req, " strobe spacing (bad cycle/exp level)"}, sp_act, sp_exp);
        check(first_at == slen - 4, "R4 first strobe cycle", first_at, slen - 4);
        check(fl_bad == 0, "R5 filter window (bad cycle/exp level)", fl_act, fl_exp);
        check(cnt_at_done == fend, "R6 cycle_count at done", cnt_at_done, fend);
        check(dn_bad == 0, "R7 done timing (bad cycle)", dn_act, done_at);
        if (poke > 0) check(sp_bad == 0 && dn_bad == 0, "R8 mid-run start", dn_act, 0);
        if (flip > 0) check(sp_bad == 0 && cnt_at_done == fend, "R9 resolution held", cnt_at_done, fend);
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int quiet;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!conv_strobe && !filt_active && !done, "R10 outputs after reset", int'(done), 0);
        check(cycle_count == 0 && conv_idx == 0, "R10 counters after reset", int'(cycle_count), 0);

        // Idle with no start: nothing happens
        quiet = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (conv_strobe || done || filt_active) quiet++;
        end
        check(quiet == 0, "R8 idle without start", quiet, 0);

        for (int v = 0; v < NV; v++) begin
            run_meas(VECS[v].res, int'(VECS[v].extra), int'(VECS[v].poke), int'(VECS[v].flip));
            repeat (2) @(negedge clk);
        end

        // Reset in the middle of a burst
        @(negedge clk);
        res_12b = 1'b1;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!conv_strobe && !filt_active && !done, "R10 mid-run reset outputs", int'(filt_active), 0);
        check(cycle_count == 0 && conv_idx == 0, "R10 mid-run reset counters", int'(cycle_count), 0);
        quiet = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (conv_strobe || done || filt_active) quiet++;
        end
        check(quiet == 0, "R10 quiet after reset", quiet, 0);

        // A fresh measurement after reset still runs to its full length
        run_meas(1'b0, 0, 0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule